// File: doc/BRIEF.md
# Big-Endian Sub-Word Data Memory

This block is a synchronous data memory organised as 64-bit words that serves aligned loads and stores of one, two, four or eight bytes. A byte address is split into a word index (the upper bits) and a three-bit byte offset. Narrow accesses address byte lanes in big-endian order: offset 0 names the most significant byte of the word.

A load returns the addressed bytes right-justified and zero-extended to 64 bits, one cycle after the request is taken. A full-word store overwrites its word directly. A narrow store reads the containing word, replaces only the addressed lane, and writes the word back. This read-modify-write takes one extra cycle, and the block shows it on a busy output. Requests whose offset is not a multiple of the access size are refused with an error response and have no effect on memory.

Top module: `be_subword_mem`

## Requirements
- R1: The word index is `req_addr[ADDR_W-1:3]` and the byte offset is `req_addr[2:0]`. Each word holds 8 bytes, and offset 0 is bits 63:56 of the word (big-endian lane order).
- R2: `req_size` encodes the access size: 2'b00 is 1 byte, 2'b01 is 2 bytes, 2'b10 is 4 bytes and 2'b11 is 8 bytes. Store data is taken from the low size×8 bits of `req_wdata`.
- R3: A request whose offset is not a multiple of its size gets `rsp_valid` and `rsp_err` high for one cycle in the next cycle, with `rsp_rdata` zero, and it leaves memory unchanged.
- R4: An aligned load taken at a clock edge gives `rsp_valid` after that edge, with the addressed bytes right-justified in `rsp_rdata` and the upper bits zero.
- R5: An aligned 8-byte store replaces the whole word at the edge that takes it. `rsp_valid` follows in the next cycle with `rsp_rdata` zero, and `busy` stays low.
- R6: An aligned narrow store raises `busy` for exactly one cycle after it is taken. `rsp_valid` follows one cycle later, and only the addressed lane of the word changes.
- R7: After reset every word reads as zero until it is written, and a narrow store into such a word merges into zero.
- R8: While `busy` is high, `req_valid` is ignored and has no effect on memory or responses.
- R9: A load taken in the cycle in which `busy` falls returns the word as updated by the narrow store.
- R10: During and right after reset, `rsp_valid`, `rsp_err` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Access size code |
| req_wdata | input | 64 | Store data, right-justified |
| busy | output | 1 | Narrow-store merge in progress; requests ignored |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_rdata | output | 64 | Load result, zero-extended |
| rsp_err | output | 1 | Request was misaligned and was not performed |

## Verification
The bench uses the default depth of 16 words, so the address is 7 bits wide. That makes the highest word (index 15, offset 7) and words that were never written easy to reach alongside the low words. With a depth this small, a vector table can walk every size code, both aligned and misaligned offsets, and every lane position that matters for the big-endian shift. The timing checks tell single-cycle responses apart from the two-cycle merge path.

// File: rtl/be_mem_pkg.sv
package be_mem_pkg;
  localparam int unsigned WORD_BYTES = 8;
  localparam int unsigned OFF_W      = $clog2(WORD_BYTES);
  localparam int unsigned DATA_W     = WORD_BYTES * 8;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_DWORD = 2'b11
  } size_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_MERGE = 1'b1
  } state_e;
endpackage

// File: rtl/be_lane_align.sv
module be_lane_align
  import be_mem_pkg::*;
#(
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned OW  = OFF_W,
  parameter int unsigned WB  = WORD_BYTES
) (
  input  logic [OW-1:0] off,
  input  logic [1:0]    size,
  input  logic [DW-1:0] word,
  input  logic [DW-1:0] wdata,
  output logic          misalign,
  output logic [DW-1:0] load_val,
  output logic [DW-1:0] merged
);
  localparam int unsigned LW = OW + 1;
  localparam int unsigned SW = OW + 4;

  logic [LW-1:0] nbytes;
  logic [OW-1:0] low_mask;
  logic [LW-1:0] lane_pos;
  logic [SW-1:0] shamt;
  logic [DW-1:0] lane_mask;
  logic [DW-1:0] placed_mask;

  always_comb begin
    nbytes      = LW'(1) << size;
    low_mask    = OW'(nbytes - LW'(1));
    misalign    = (off & low_mask) != '0;
    lane_pos    = LW'(WB) - nbytes - {1'b0, off};
    shamt       = {1'b0, lane_pos, 3'b000};
    if (size_e'(size) == SZ_DWORD) lane_mask = '1;
    else lane_mask = (DW'(1) << {nbytes, 3'b000}) - DW'(1);
    placed_mask = lane_mask << shamt;
    load_val    = (word & placed_mask) >> shamt;
    merged      = (word & ~placed_mask) | ((wdata & lane_mask) << shamt);
  end
endmodule

// File: rtl/be_word_store.sv
module be_word_store
  import be_mem_pkg::*;
#(
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data
);
  logic [DW-1:0]    mem_q [DEPTH];
  logic [DEPTH-1:0] filled_q;
  logic [DEPTH-1:0] filled_d;

  always_comb begin
    filled_d = filled_q;
    if (wr_en) filled_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) filled_q <= '0;
    else filled_q <= filled_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IW'(g))) mem_q[g] <= wr_data;
    end
  end

  assign rd_data = filled_q[rd_idx] ? mem_q[rd_idx] : '0;

  // R5 R6: a committed write is what the word holds afterwards
  assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (filled_q[$past(wr_idx)] && mem_q[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/be_access_ctrl.sv
module be_access_ctrl
  import be_mem_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned OW = OFF_W,
  parameter int unsigned IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_store,
  input  logic [IW-1:0] req_idx,
  input  logic [OW-1:0] req_off,
  input  logic [1:0]    req_size,
  input  logic [DW-1:0] req_wdata,
  input  logic          misalign,
  input  logic [DW-1:0] load_val,
  input  logic [DW-1:0] merged,
  output logic [IW-1:0] sel_idx,
  output logic [OW-1:0] sel_off,
  output logic [1:0]    sel_size,
  output logic [DW-1:0] sel_wdata,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [DW-1:0] wr_data,
  output logic          busy,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_err
);
  state_e        state_q, state_d;
  logic [IW-1:0] lat_idx_q;
  logic [OW-1:0] lat_off_q;
  logic [1:0]    lat_size_q;
  logic [DW-1:0] lat_wdata_q;
  logic          lat_en;
  logic          rsp_valid_d, rsp_err_d;
  logic [DW-1:0] rsp_rdata_d;
  logic          accept;

  assign busy   = (state_q == ST_MERGE);
  assign accept = req_valid && !busy;

  always_comb begin
    if (busy) begin
      sel_idx   = lat_idx_q;
      sel_off   = lat_off_q;
      sel_size  = lat_size_q;
      sel_wdata = lat_wdata_q;
    end else begin
      sel_idx   = req_idx;
      sel_off   = req_off;
      sel_size  = req_size;
      sel_wdata = req_wdata;
    end
  end

  always_comb begin
    state_d     = state_q;
    lat_en      = 1'b0;
    wr_en       = 1'b0;
    wr_idx      = sel_idx;
    wr_data     = sel_wdata;
    rsp_valid_d = 1'b0;
    rsp_err_d   = 1'b0;
    rsp_rdata_d = '0;
    if (busy) begin
      wr_en       = 1'b1;
      wr_data     = merged;
      state_d     = ST_IDLE;
      rsp_valid_d = 1'b1;
    end else if (accept) begin
      if (misalign) begin
        rsp_valid_d = 1'b1;
        rsp_err_d   = 1'b1;
      end else if (!req_store) begin
        rsp_valid_d = 1'b1;
        rsp_rdata_d = load_val;
      end else if (size_e'(req_size) == SZ_DWORD) begin
        wr_en       = 1'b1;
        rsp_valid_d = 1'b1;
      end else begin
        lat_en  = 1'b1;
        state_d = ST_MERGE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      state_q   <= state_d;
      rsp_valid <= rsp_valid_d;
      rsp_err   <= rsp_err_d;
      rsp_rdata <= rsp_rdata_d;
    end
  end

  always_ff @(posedge clk) begin
    if (lat_en) begin
      lat_idx_q   <= req_idx;
      lat_off_q   <= req_off;
      lat_size_q  <= req_size;
      lat_wdata_q <= req_wdata;
    end
  end

  assert_busy_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
  assert_merge_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (rsp_valid && !rsp_err));
  assert_narrow_enters_merge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_store && !misalign && req_size != 2'b11) |=> busy);
  assert_err_is_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && rsp_rdata == '0));
endmodule

// File: rtl/be_subword_mem.sv
module be_subword_mem
  import be_mem_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned IW    = $clog2(DEPTH),
  localparam int unsigned ADDR_W = IW + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err
);
  logic              rst_s1_q, rst_s2_q;
  logic [IW-1:0]     sel_idx, wr_idx;
  logic [OFF_W-1:0]  sel_off;
  logic [1:0]        sel_size;
  logic [DATA_W-1:0] sel_wdata, rd_word, load_val, merged, wr_data;
  logic              misalign, wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  be_word_store #(.DW(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_s2_q), .rd_idx(sel_idx), .rd_data(rd_word),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  be_lane_align #(.DW(DATA_W), .OW(OFF_W), .WB(WORD_BYTES)) u_align (
    .off(sel_off), .size(sel_size), .word(rd_word), .wdata(sel_wdata),
    .misalign(misalign), .load_val(load_val), .merged(merged)
  );

  be_access_ctrl #(.DW(DATA_W), .OW(OFF_W), .IW(IW)) u_ctrl (
    .clk(clk), .rst_n(rst_s2_q),
    .req_valid(req_valid), .req_store(req_store),
    .req_idx(req_addr[ADDR_W-1:OFF_W]), .req_off(req_addr[OFF_W-1:0]),
    .req_size(req_size), .req_wdata(req_wdata),
    .misalign(misalign), .load_val(load_val), .merged(merged),
    .sel_idx(sel_idx), .sel_off(sel_off), .sel_size(sel_size), .sel_wdata(sel_wdata),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
  );
endmodule

// File: tb/be_subword_mem_bench.sv
module be_subword_mem_bench;
  localparam int unsigned AW = 7;
  localparam int unsigned NV = 20;

  typedef struct packed {
    logic        st;
    logic [6:0]  addr;
    logic [1:0]  size;
    logic [63:0] wdata;
    logic [63:0] exp;
    logic        err;
  } vec_t;

  // R1 R2 R3 R4 R5 R6 R7 stimulus and expected results
  localparam vec_t VEC [NV] = '{
    '{1'b1, 7'h08, 2'b11, 64'h0011223344556677, 64'h0, 1'b0}, // R5 full store
    '{1'b0, 7'h08, 2'b11, 64'h0, 64'h0011223344556677, 1'b0}, // R4
    '{1'b0, 7'h08, 2'b00, 64'h0, 64'h00, 1'b0},               // R1 offset 0 = MSB
    '{1'b0, 7'h0F, 2'b00, 64'h0, 64'h77, 1'b0},
    '{1'b0, 7'h0A, 2'b01, 64'h0, 64'h2233, 1'b0},
    '{1'b0, 7'h0C, 2'b10, 64'h0, 64'h44556677, 1'b0},
    '{1'b1, 7'h09, 2'b00, 64'hFFFFFFFFFFFFFFAB, 64'h0, 1'b0}, // R6 R2 low bits
    '{1'b0, 7'h08, 2'b11, 64'h0, 64'h00AB223344556677, 1'b0},
    '{1'b1, 7'h0E, 2'b01, 64'h000000001234BEEF, 64'h0, 1'b0},
    '{1'b0, 7'h08, 2'b11, 64'h0, 64'h00AB22334455BEEF, 1'b0},
    '{1'b1, 7'h08, 2'b10, 64'h00000000CAFEF00D, 64'h0, 1'b0},
    '{1'b0, 7'h08, 2'b11, 64'h0, 64'hCAFEF00D4455BEEF, 1'b0},
    '{1'b0, 7'h09, 2'b01, 64'h0, 64'h0, 1'b1},                // R3
    '{1'b1, 7'h0A, 2'b10, 64'hFFFFFFFFFFFFFFFF, 64'h0, 1'b1}, // R3 store
    '{1'b0, 7'h08, 2'b11, 64'h0, 64'hCAFEF00D4455BEEF, 1'b0}, // R3 unchanged
    '{1'b0, 7'h0C, 2'b11, 64'h0, 64'h0, 1'b1},
    '{1'b0, 7'h70, 2'b00, 64'h0, 64'h0, 1'b0},                // R7
    '{1'b1, 7'h7F, 2'b00, 64'h000000000000005A, 64'h0, 1'b0}, // R7 merge into zero
    '{1'b0, 7'h78, 2'b11, 64'h0, 64'h000000000000005A, 1'b0},
    '{1'b0, 7'h7C, 2'b10, 64'h0, 64'h000000000000005A, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_store = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = '0;
  logic [63:0]   req_wdata = '0;
  logic          busy, rsp_valid, rsp_err;
  logic [63:0]   rsp_rdata;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  be_subword_mem u_be_subword_mem (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic st, input logic [AW-1:0] addr, input logic [1:0] size,
                        input logic [63:0] wd, output logic [63:0] rd, output logic er,
                        output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_addr = addr; req_size = size; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 8) begin
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
    er = rsp_err;
  endtask

  function automatic string tag_of(vec_t v);
    if (v.err) return "R3 (R1 R2)";
    if (!v.st) return "R4 (R1 R2)";
    if (v.size == 2'b11) return "R5 (R1 R2)";
    return "R6 (R1 R2)";
  endfunction

  initial begin
    #(8 * 20000);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] rd;
    logic        er;
    int          lat;
    repeat (3) @(negedge clk);
    // R10 during reset
    check("R10 rsp_valid in reset", 64'(rsp_valid), 64'h0);
    check("R10 busy in reset", 64'(busy), 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 rsp_valid after reset", 64'(rsp_valid), 64'h0);
    check("R10 rsp_err after reset", 64'(rsp_err), 64'h0);
    check("R10 busy after reset", 64'(busy), 64'h0);

    for (int i = 0; i < NV; i++) begin
      int exp_lat;
      do_req(VEC[i].st, VEC[i].addr, VEC[i].size, VEC[i].wdata, rd, er, lat);
      exp_lat = (VEC[i].st && !VEC[i].err && VEC[i].size != 2'b11) ? 2 : 1;
      check({tag_of(VEC[i]), " data"}, rd, VEC[i].exp);
      check({tag_of(VEC[i]), " err"}, 64'(er), 64'(VEC[i].err));
      check({tag_of(VEC[i]), " latency"}, 64'(lat), 64'(exp_lat));
    end

    // R7: untouched word reads zero
    do_req(1'b0, 7'h40, 2'b11, 64'h0, rd, er, lat);
    check("R7 unwritten word", rd, 64'h0);

    // R8: request while busy is ignored
    @(negedge clk);
    req_valid = 1'b1; req_store = 1'b1; req_addr = 7'h10; req_size = 2'b00;
    req_wdata = 64'h11;
    @(negedge clk);
    check("R6 busy after narrow store", 64'(busy), 64'h1);
    req_store = 1'b1; req_addr = 7'h20; req_size = 2'b11; req_wdata = 64'hDEADDEADDEADDEAD;
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 rsp after merge", 64'(rsp_valid), 64'h1);
    @(negedge clk);
    check("R8 no extra response", 64'(rsp_valid), 64'h0);
    do_req(1'b0, 7'h20, 2'b11, 64'h0, rd, er, lat);
    check("R8 ignored store left word zero", rd, 64'h0);

    // R9: load right as busy falls sees merged word
    @(negedge clk);
    req_valid = 1'b1; req_store = 1'b1; req_addr = 7'h13; req_size = 2'b00;
    req_wdata = 64'hC3;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check("R9 merge response", 64'(rsp_valid), 64'h1);
    req_valid = 1'b1; req_store = 1'b0; req_addr = 7'h10; req_size = 2'b11;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 load valid", 64'(rsp_valid), 64'h1);
    check("R9 load sees update", rsp_rdata, 64'h110000C300000000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule